// File: doc/BRIEF.md
# Wilkinson Rundown Conversion Controller

This block sequences a rundown-style time-to-digital conversion around an external capacitor. A start event opens the charge phase, during which a large constant current flows into the capacitor. A stop event closes it. The charge phase therefore lasts exactly as long as the interval being measured. The controller then switches to a far smaller discharge current. Because the discharge current is so much smaller, the capacitor takes many times longer to empty than it took to fill, and this stretches the measured interval. While a comparator reports that charge remains, a counter driven by the fast conversion clock advances. The count it reaches when the capacitor is empty is the result.

The analog parts appear only as digital handshakes. The block drives two enables, one for the charge source and one for the rundown source, and it reads one comparator flag that goes high when the capacitor is empty. The conversion clock sets both the resolution and the conversion time: each count is one clock period of rundown. A finished result is presented with a done flag, which stays up until the host acknowledges it. If the counter fills before the comparator trips, the result is marked as out of range.

Top module: `wilk_conv_ctrl`

## Requirements
- R1: After reset, charge_en_o, rundown_en_o, done_o and ovf_o are all 0 and result_o is 0.
- R2: A stop event while the block is idle has no effect. No enable rises and done_o stays 0.
- R3: A start rising edge while idle raises charge_en_o from the next cycle. charge_en_o stays high for exactly as many cycles as there are clock edges between the edge that sampled start and the edge that sampled stop.
- R4: A start rising edge during charge, rundown or done is ignored. The charge length, the result and done_o are unaffected.
- R5: The cycle after stop is sampled during charge, charge_en_o is 0, rundown_en_o is 1 and result_o is 0.
- R6: During rundown, the count grows by one on every edge at which empty_i is 0. The result equals the number of such edges.
- R7: An edge during rundown at which empty_i is 1 ends the rundown. From the next cycle rundown_en_o is 0, done_o is 1 and result_o holds the count.
- R8: If empty_i is still 0 at an edge where the count is all ones, the conversion ends with result_o all ones and ovf_o 1. If empty_i is 1 at that edge, it wins: the result is all ones and ovf_o is 0. ovf_o is only ever 1 while done_o is 1.
- R9: done_o and result_o hold until ack_i is sampled high. The cycle after that, done_o is 0 and the block is idle. ack_i outside the done state has no effect.
- R10: charge_en_o and rundown_en_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion (counting) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start of the interval being measured (rising edge used) |
| stop_i | input | 1 | End of the interval being measured (rising edge used) |
| empty_i | input | 1 | Rundown comparator: 1 when the capacitor is empty |
| ack_i | input | 1 | Host acknowledge of a finished result |
| charge_en_o | output | 1 | Enables the large charge current |
| rundown_en_o | output | 1 | Enables the small discharge current |
| result_o | output | CNT_W | Conversion count |
| done_o | output | 1 | Result is valid and held |
| ovf_o | output | 1 | Counter filled before the comparator tripped |

## Verification
The bench goes after the counter boundary, running one conversion that trips the comparator exactly at the full count and one that stays in rundown one edge longer. A design that checks saturation before the comparator would flag a valid full-scale result as out of range. A design that wraps the counter would report a small count with no flag. The bench also sends stray start and acknowledge pulses in the middle of a charge phase. A controller that restarts or leaves its state early would show a charge length different from the interval the bench drove. Finally, the bench checks that the count is cleared on entry to rundown. A design that kept the previous result would be off by that amount on the conversion that follows an overflow.

// File: rtl/wilk_pkg.sv
package wilk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_CHARGE  = 2'd1,
      ST_RUNDOWN = 2'd2,
      ST_DONE    = 2'd3
   } wilk_state_t;
endpackage

// File: rtl/wilk_evt.sv
module wilk_evt #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic evt_o
);
   generate
      if (EDGE_MODE) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= sig_i;
         end
         assign evt_o = sig_i & ~prev_q;
      end else begin : g_level
         assign evt_o = sig_i;
      end
   endgenerate
endmodule

// File: rtl/wilk_count.sv
module wilk_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic             empty_i,
   output logic [CNT_W-1:0] count_o,
   output logic             at_max_o,
   output logic             ovf_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] count_q;
   logic             ovf_q;

   assign at_max_o = (count_q == CNT_MAX);
   assign count_o  = count_q;
   assign ovf_o    = ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         ovf_q   <= 1'b0;
      end else if (clr_i) begin
         count_q <= '0;
         ovf_q   <= 1'b0;
      end else if (run_i && !empty_i) begin
         if (at_max_o) ovf_q   <= 1'b1;
         else          count_q <= count_q + 1'b1;
      end
   end

   // R6: each rundown edge with charge remaining advances the count by one
   p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !empty_i && !at_max_o && !clr_i) |=> (count_q == $past(count_q) + 1'b1));

   // R8: the overflow flag only ever appears with a full counter
   p_ovf_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> (count_q == CNT_MAX));
endmodule

// File: rtl/wilk_seq.sv
module wilk_seq
   import wilk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_evt_i,
   input  logic stop_evt_i,
   input  logic empty_i,
   input  logic at_max_i,
   input  logic ack_i,
   output logic clr_o,
   output logic charge_o,
   output logic run_o,
   output logic done_o
);
   wilk_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (start_evt_i)          state_d = ST_CHARGE;
         ST_CHARGE:  if (stop_evt_i)           state_d = ST_RUNDOWN;
         ST_RUNDOWN: if (empty_i || at_max_i)  state_d = ST_DONE;
         ST_DONE:    if (ack_i)                state_d = ST_IDLE;
         default:                              state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign clr_o    = (state_q == ST_CHARGE) && stop_evt_i;
   assign charge_o = (state_q == ST_CHARGE);
   assign run_o    = (state_q == ST_RUNDOWN);
   assign done_o   = (state_q == ST_DONE);

   // R4: a start edge inside a conversion leaves the sequence where it is
   p_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !ack_i && start_evt_i) |=> done_o);
endmodule

// File: rtl/wilk_conv_ctrl.sv
module wilk_conv_ctrl #(
   parameter int CNT_W     = 8,
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             empty_i,
   input  logic             ack_i,
   output logic             charge_en_o,
   output logic             rundown_en_o,
   output logic [CNT_W-1:0] result_o,
   output logic             done_o,
   output logic             ovf_o
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("wilk_conv_ctrl: CNT_W must lie in 2..32");
      end
   endgenerate

   logic start_evt, stop_evt, clr, run, at_max, ovf_raw;

   wilk_evt #(.EDGE_MODE(EDGE_MODE)) u_start_evt (
      .clk(clk), .rst_n(rst_n), .sig_i(start_i), .evt_o(start_evt));
   wilk_evt #(.EDGE_MODE(EDGE_MODE)) u_stop_evt (
      .clk(clk), .rst_n(rst_n), .sig_i(stop_i), .evt_o(stop_evt));

   wilk_seq u_seq (
      .clk(clk), .rst_n(rst_n),
      .start_evt_i(start_evt), .stop_evt_i(stop_evt),
      .empty_i(empty_i), .at_max_i(at_max), .ack_i(ack_i),
      .clr_o(clr), .charge_o(charge_en_o), .run_o(run), .done_o(done_o));

   wilk_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .run_i(run),
      .empty_i(empty_i), .count_o(result_o), .at_max_o(at_max),
      .ovf_o(ovf_raw));

   assign rundown_en_o = run;
   assign ovf_o        = ovf_raw & done_o;

   // R10: the two current sources are never enabled together
   p_excl_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(charge_en_o && rundown_en_o));

   // R5: stop during charge hands over to rundown with a cleared count
   p_rundown_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (charge_en_o && stop_evt) |=> (rundown_en_o && !charge_en_o && result_o == '0));

   // R9: a result is held until acknowledged
   p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !ack_i) |=> (done_o && $stable(result_o)));

   // R2: a stop seen while idle does not start anything
   p_idle_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!charge_en_o && !rundown_en_o && !done_o && !start_evt) |=> !charge_en_o);
endmodule

// File: tb/wilk_conv_ctrl_test.sv
module wilk_conv_ctrl_test;
   localparam int CNT_W = 8;
   localparam int MAXV  = (1 << CNT_W) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 1'b0, stop_i = 1'b0, empty_i = 1'b1, ack_i = 1'b0;
   logic charge_en_o, rundown_en_o, done_o, ovf_o;
   logic [CNT_W-1:0] result_o;

   always #5 clk = ~clk;

   wilk_conv_ctrl #(.CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .empty_i(empty_i), .ack_i(ack_i), .charge_en_o(charge_en_o),
      .rundown_en_o(rundown_en_o), .result_o(result_o),
      .done_o(done_o), .ovf_o(ovf_o));

   typedef struct { int res; bit ovf; } exp_t;
   exp_t exp_q[$];
   int n_checks = 0, n_errs = 0;
   bit finished = 1'b0;
   logic done_d = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: compares each finished result against the scoreboard
   always @(negedge clk) begin
      if (rst_n && done_o && !done_d) begin
         if (exp_q.size() == 0) chk(1'b0, "R7 unexpected done", 1, 0);
         else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(int'(result_o) == e.res, "R6/R8 result", int'(result_o), e.res);
            chk(ovf_o == e.ovf, "R8 overflow flag", int'(ovf_o), int'(e.ovf));
         end
      end
      done_d = done_o;
   end

   // driver: one full conversion with clen charge cycles and k rundown edges
   task automatic conv(input int clen, input int k, input bit poke);
      int n;
      exp_t e;
      logic [CNT_W-1:0] held;
      e.res = (k > MAXV) ? MAXV : k;
      e.ovf = (k > MAXV);
      exp_q.push_back(e);
      @(negedge clk); start_i = 1'b1; empty_i = 1'b0;
      @(negedge clk); start_i = 1'b0;
      n = 0;
      for (int i = 0; i < clen; i++) begin
         if (charge_en_o) n++;
         if (poke && i == 1) begin start_i = 1'b1; ack_i = 1'b1; end
         if (poke && i == 2) begin start_i = 1'b0; ack_i = 1'b0; end
         if (i == clen - 1) stop_i = 1'b1;
         @(negedge clk);
      end
      stop_i = 1'b0; start_i = 1'b0; ack_i = 1'b0;
      chk(n == clen, poke ? "R4 charge length with stray start/ack" : "R3 charge length", n, clen);
      chk(!charge_en_o && rundown_en_o, "R5 handover to rundown", int'(rundown_en_o), 1);
      chk(result_o == '0, "R5 count cleared", int'(result_o), 0);
      for (int i = 0; i < k && !done_o; i++) @(negedge clk);
      empty_i = 1'b1;
      while (!done_o) @(negedge clk);
      chk(!rundown_en_o && !charge_en_o, "R7 rundown stops", int'(rundown_en_o), 0);
      held = result_o;
      start_i = 1'b1; @(negedge clk); start_i = 1'b0; @(negedge clk);
      chk(done_o && !charge_en_o, "R4 start ignored in done", int'(charge_en_o), 0);
      chk(result_o == held, "R9 result held", int'(result_o), int'(held));
      ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
      chk(!done_o && !ovf_o && !charge_en_o && !rundown_en_o, "R9 ack returns idle",
          int'(done_o), 0);
   endtask

   initial begin
      #100000;
      if (!finished) begin
         n_checks++; n_errs++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!charge_en_o && !rundown_en_o && !done_o && !ovf_o && result_o == '0,
          "R1 reset state", int'(result_o), 0);
      stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
      repeat (2) @(negedge clk);
      chk(!charge_en_o && !rundown_en_o && !done_o, "R2 stop while idle", int'(charge_en_o), 0);
      conv(5, 0, 1'b0);
      conv(3, 1, 1'b0);
      conv(6, 17, 1'b1);
      conv(1, 40, 1'b0);
      conv(4, MAXV, 1'b0);      // R8: empty on the edge at full count wins
      conv(4, MAXV + 1, 1'b0);  // R8: one edge longer overflows
      conv(2, 300, 1'b0);
      conv(7, 9, 1'b1);         // R6: count restarts from zero after overflow
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule